// File: doc/BRIEF.md
# Ethernet Destination Address Filter with Multicast Hash

This block decides whether a received Ethernet frame is kept, judging only by its 48-bit destination address. The address arrives one byte per accepted beat, with the first byte marked by a start flag and the sixth byte marked by an end flag. While the bytes stream in, the block does two things at once. It compares each byte against the programmed station address. It also advances a CRC-32 over the address bits. One clock after the last byte it gives a verdict and a valid flag. Both hold until the next frame starts.

Three mode inputs set the filtering policy:
- **Promiscuous:** every frame is accepted.
- **Pass-all-multicast:** every group address is accepted.
- **Hash:** group addresses are looked up in a 64-bit table held as two 32-bit words.
- **All three clear:** only exact unicast matches pass.

A broadcast destination is always accepted. A unicast destination outside promiscuous mode must equal the station address exactly.

Top module: `mac_da_filter`

## Requirements
- R1: After reset, `verdict_vld` and `verdict_accept` are both 0.
- R2: `verdict_vld` rises in the cycle after the beat that carries `da_last`. It and `verdict_accept` then stay constant until a beat carrying `da_first`, which clears both.
- R3: With `mode_prom` set, every frame is accepted, whatever the address or hash table holds.
- R4: A destination of all ones (broadcast) is accepted in every mode.
- R5: A destination is unicast when bit 0 of its first byte is 0. Outside promiscuous mode, a unicast frame is accepted only when address byte k (k = 0 first on the wire) equals `station_addr[8k+7:8k]` for all six bytes.
- R6: With `mode_mc_all` set, every multicast destination (bit 0 of the first byte is 1) is accepted, regardless of the hash table.
- R7: In hash mode (`mode_mc_hash` set, `mode_prom` and `mode_mc_all` clear), a non-broadcast multicast frame is accepted exactly when its indexed hash bit is 1. The index is bits 31:26 of a CRC-32 register that:
  - starts at 0xFFFFFFFF,
  - uses polynomial 0x04C11DB7,
  - is fed the address bytes in order, each byte least significant bit first,
  - is used without final inversion.
- R8: Index bit 5 selects the word: 1 picks `hash_hi` and 0 picks `hash_lo`. Index bits 4:0 give the bit position, 0 to 31, within that word.
- R9: With all three mode inputs clear, non-broadcast multicast frames are rejected.
- R10: Cycles with `da_vld` low have no effect. The values on `da_byte`, `da_first` and `da_last` in those cycles change neither the verdict nor the frame being assembled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| da_vld | input | 1 | Address byte beat valid |
| da_first | input | 1 | Beat carries the first address byte |
| da_last | input | 1 | Beat carries the last address byte |
| da_byte | input | 8 | Address byte |
| station_addr | input | 48 | Station address, byte k at bits 8k+7:8k |
| hash_hi | input | 32 | Hash table word for index bit 5 = 1 |
| hash_lo | input | 32 | Hash table word for index bit 5 = 0 |
| mode_prom | input | 1 | Promiscuous mode |
| mode_mc_all | input | 1 | Accept all multicast |
| mode_mc_hash | input | 1 | Filter multicast through the hash table |
| verdict_vld | output | 1 | Verdict available |
| verdict_accept | output | 1 | Frame accepted (meaningful when verdict_vld is 1) |

## Verification
The bench crosses all eight combinations of the mode inputs with a set of addresses:
- the exact station address,
- six copies with a single byte changed, which separates a full-address compare from a partial one,
- broadcast,
- several group addresses.

For a group of multicast addresses in hash mode, it then sweeps a one-hot table over all 64 positions, and a table with a single cleared bit over all 64 positions. Each address must be accepted at exactly one position (or rejected at exactly one position). This pins the CRC polynomial, the bit order, the word choice and the bit select independently. Further frames carry idle gaps filled with junk bytes and stray flags, to show that only valid beats count.

// File: rtl/mdf_pkg.sv
package mdf_pkg;

  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

  typedef struct packed {
    logic prom;
    logic mc_all;
    logic mc_hash;
  } filt_mode_t;

  // Advance a left-shifting CRC-32 over one byte, least significant bit first.
  function automatic logic [31:0] crc_step_byte(input logic [31:0] c_in,
                                                input logic [7:0]  d);
    logic [31:0] c;
    logic        fb;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[31] ^ d[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/mdf_crc_acc.sv
module mdf_crc_acc
  import mdf_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             first,
  input  logic [7:0]       data,
  output logic [IDX_W-1:0] index_nxt
);

  logic [31:0] crc_q;
  logic [31:0] crc_base;
  logic [31:0] crc_nxt;
  logic [31:0] crc_d;

  // A first beat restarts from the seed regardless of leftover state.
  always_comb begin
    crc_base  = first ? CRC_SEED : crc_q;
    crc_nxt   = crc_step_byte(crc_base, data);
    crc_d     = beat ? crc_nxt : crc_q;
    index_nxt = crc_nxt[31 -: IDX_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_SEED;
    else        crc_q <= crc_d;
  end

  // R10: idle cycles leave the running CRC untouched
  p_crc_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> $stable(crc_q));

endmodule

// File: rtl/mdf_addr_track.sv
module mdf_addr_track #(
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    beat,
  input  logic                    first,
  input  logic [7:0]              data,
  input  logic [8*ADDR_BYTES-1:0] station,
  output logic                    match_nxt,
  output logic                    mcast_nxt,
  output logic                    bcast_nxt
);

  localparam int POS_W = $clog2(ADDR_BYTES + 1);
  localparam int BI_W  = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(ADDR_BYTES);

  logic [7:0]       sta_b [ADDR_BYTES];
  logic [POS_W-1:0] pos_q, pos_d, cur_pos;
  logic             match_q, mcast_q, bcast_q;
  logic             match_d, mcast_d, bcast_d;
  logic             in_rng, byte_eq;
  logic [7:0]       ref_byte;

  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_sta
    assign sta_b[k] = station[8*k +: 8];
  end

  always_comb begin
    cur_pos  = first ? '0 : pos_q;
    in_rng   = cur_pos < LAST_POS;
    ref_byte = in_rng ? sta_b[cur_pos[BI_W-1:0]] : 8'h00;
    byte_eq  = in_rng && (data == ref_byte);

    match_nxt = first ? byte_eq        : (match_q && byte_eq);
    mcast_nxt = first ? data[0]        : mcast_q;
    bcast_nxt = first ? (&data)        : (bcast_q && (&data));

    pos_d   = pos_q;
    match_d = match_q;
    mcast_d = mcast_q;
    bcast_d = bcast_q;
    if (beat) begin
      pos_d   = (cur_pos == LAST_POS) ? LAST_POS : cur_pos + 1'b1;
      match_d = match_nxt;
      mcast_d = mcast_nxt;
      bcast_d = bcast_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      match_q <= 1'b0;
      mcast_q <= 1'b0;
      bcast_q <= 1'b0;
    end else begin
      pos_q   <= pos_d;
      match_q <= match_d;
      mcast_q <= mcast_d;
      bcast_q <= bcast_d;
    end
  end

  // R10: byte position only moves on valid beats
  p_pos_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> $stable(pos_q) && $stable(match_q));

  // R5: a first beat always restarts the position at one
  p_pos_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && first) |=> (pos_q == POS_W'(1)));

endmodule

// File: rtl/mdf_decide.sv
module mdf_decide
  import mdf_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              first,
  input  logic              last,
  input  filt_mode_t        mode,
  input  logic              match,
  input  logic              mcast,
  input  logic              bcast,
  input  logic [IDX_W-1:0]  index,
  input  logic [WORD_W-1:0] word_hi,
  input  logic [WORD_W-1:0] word_lo,
  output logic              vld,
  output logic              accept
);

  logic [WORD_W-1:0] word_sel;
  logic              hash_hit, verdict;
  logic              vld_q, vld_d, acc_q, acc_d;

  always_comb begin
    word_sel = index[IDX_W-1] ? word_hi : word_lo;
    hash_hit = word_sel[index[IDX_W-2:0]];
    if (bcast || mode.prom) verdict = 1'b1;
    else if (mcast)         verdict = mode.mc_all || (mode.mc_hash && hash_hit);
    else                    verdict = match;

    vld_d = vld_q;
    acc_d = acc_q;
    if (beat && last) begin
      vld_d = 1'b1;
      acc_d = verdict;
    end else if (beat && first) begin
      vld_d = 1'b0;
      acc_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      acc_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      acc_q <= acc_d;
    end
  end

  assign vld    = vld_q;
  assign accept = acc_q;

  p_last_gives_vld_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && last) |=> vld);

  p_first_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && first && !last) |=> !vld && !accept);

  p_verdict_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !(beat && (first || last))) |=> vld && $stable(accept));

  p_prom_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && last && mode.prom) |=> accept);

  p_bcast_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && last && bcast) |=> accept);

  p_mc_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && last && mcast && mode.mc_all) |=> accept);

  p_mc_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && last && mcast && !bcast && !mode.prom && !mode.mc_all && !mode.mc_hash)
    |=> !accept);

endmodule

// File: rtl/mac_da_filter.sv
module mac_da_filter
  import mdf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int IDX_W      = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    da_vld,
  input  logic                    da_first,
  input  logic                    da_last,
  input  logic [7:0]              da_byte,
  input  logic [8*ADDR_BYTES-1:0] station_addr,
  input  logic [31:0]             hash_hi,
  input  logic [31:0]             hash_lo,
  input  logic                    mode_prom,
  input  logic                    mode_mc_all,
  input  logic                    mode_mc_hash,
  output logic                    verdict_vld,
  output logic                    verdict_accept
);

  localparam int WORD_W = 2 ** (IDX_W - 1);

  filt_mode_t       mode;
  logic             match_nxt, mcast_nxt, bcast_nxt;
  logic [IDX_W-1:0] index_nxt;

  assign mode = '{prom: mode_prom, mc_all: mode_mc_all, mc_hash: mode_mc_hash};

  mdf_crc_acc #(.IDX_W(IDX_W)) u_crc (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (da_vld),
    .first     (da_first),
    .data      (da_byte),
    .index_nxt (index_nxt)
  );

  mdf_addr_track #(.ADDR_BYTES(ADDR_BYTES)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (da_vld),
    .first     (da_first),
    .data      (da_byte),
    .station   (station_addr),
    .match_nxt (match_nxt),
    .mcast_nxt (mcast_nxt),
    .bcast_nxt (bcast_nxt)
  );

  mdf_decide #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_decide (
    .clk     (clk),
    .rst_n   (rst_n),
    .beat    (da_vld),
    .first   (da_first),
    .last    (da_last),
    .mode    (mode),
    .match   (match_nxt),
    .mcast   (mcast_nxt),
    .bcast   (bcast_nxt),
    .index   (index_nxt),
    .word_hi (hash_hi[WORD_W-1:0]),
    .word_lo (hash_lo[WORD_W-1:0]),
    .vld     (verdict_vld),
    .accept  (verdict_accept)
  );

endmodule

// File: tb/mac_da_filter_bench.sv
module mac_da_filter_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        da_vld, da_first, da_last;
  logic [7:0]  da_byte;
  logic [47:0] station_addr;
  logic [31:0] hash_hi, hash_lo;
  logic        mode_prom, mode_mc_all, mode_mc_hash;
  logic        verdict_vld, verdict_accept;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [47:0] STA   = 48'h5544_3322_1102;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

  always #4 clk = ~clk;

  mac_da_filter u_mac_da_filter (
    .clk(clk), .rst_n(rst_n), .da_vld(da_vld), .da_first(da_first),
    .da_last(da_last), .da_byte(da_byte), .station_addr(station_addr),
    .hash_hi(hash_hi), .hash_lo(hash_lo), .mode_prom(mode_prom),
    .mode_mc_all(mode_mc_all), .mode_mc_hash(mode_mc_hash),
    .verdict_vld(verdict_vld), .verdict_accept(verdict_accept)
  );

  function automatic logic [5:0] ref_index(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic fb;
    for (int i = 0; i < 48; i++) begin
      fb = c[31] ^ a[i];
      c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
    end
    return c[31:26];
  endfunction

  function automatic bit ref_accept(input logic [47:0] a, input logic [2:0] m,
                                    input logic [31:0] hi, input logic [31:0] lo);
    logic [5:0] ix;
    ix = ref_index(a);
    if (a == BCAST || m[2]) return 1'b1;
    if (a[0]) return m[1] || (m[0] && (ix[5] ? hi[ix[4:0]] : lo[ix[4:0]]));
    return a == STA;
  endfunction

  function automatic string tag_of(input logic [47:0] a, input logic [2:0] m);
    if (a == BCAST) return "R4";
    if (m[2])       return "R3";
    if (!a[0])      return "R5";
    if (m[1])       return "R6";
    if (m[0])       return "R7";
    return "R9";
  endfunction

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  // Drives one address; gap adds idle cycles with junk between beats (R10).
  task automatic send(input logic [47:0] a, input bit gap);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (k == 1) chk(verdict_vld, 1'b0, "R2 cleared after first beat");
      da_vld = 1'b1; da_first = (k == 0); da_last = (k == 5);
      da_byte = a[8*k +: 8];
      if (gap && k < 5) begin
        @(negedge clk);
        da_vld = 1'b0; da_first = 1'b1; da_last = 1'b1;
        da_byte = 8'($urandom);
      end
    end
    @(negedge clk);
    da_vld = 1'b0; da_first = 1'b0; da_last = 1'b0; da_byte = 8'h00;
  endtask

  task automatic run(input logic [47:0] a, input logic [2:0] m, input string tag);
    logic exp;
    {mode_prom, mode_mc_all, mode_mc_hash} = m;
    send(a, 1'b0);
    exp = ref_accept(a, m, hash_hi, hash_lo);
    chk(verdict_vld, 1'b1, "R2 valid after last beat");
    chk(verdict_accept, exp, tag);
  endtask

  function automatic logic [47:0] mc_addr(input int i);
    return {8'(i * 37 + 5), 8'(i * 11 + 3), 8'(8'h5e + i), 8'(i * 3), 8'h00,
            8'(8'h01 | (i << 1))};
  endfunction

  initial begin
    rst_n = 1'b0; da_vld = 1'b0; da_first = 1'b0; da_last = 1'b0; da_byte = 8'h00;
    station_addr = STA; hash_hi = 32'h0; hash_lo = 32'h0;
    mode_prom = 1'b0; mode_mc_all = 1'b0; mode_mc_hash = 1'b0;
    repeat (3) @(negedge clk);
    chk(verdict_vld, 1'b0, "R1 valid at reset");
    chk(verdict_accept, 1'b0, "R1 accept at reset");
    rst_n = 1'b1;
    @(negedge clk);

    // Mode sweep over address classes
    hash_hi = 32'hA5C3_0F96; hash_lo = 32'h3C5A_F00F;
    for (int m = 0; m < 8; m++) begin
      run(STA, 3'(m), tag_of(STA, 3'(m)));
      for (int k = 0; k < 6; k++) begin
        logic [47:0] a;
        a = STA ^ (48'h40 << (8 * k));
        run(a, 3'(m), tag_of(a, 3'(m)));
      end
      run(BCAST, 3'(m), "R4 broadcast");
      for (int i = 0; i < 4; i++) run(mc_addr(i), 3'(m), tag_of(mc_addr(i), 3'(m)));
    end

    // Verdict holds over idle cycles (R2)
    run(STA, 3'b000, "R5 exact");
    repeat (4) @(negedge clk);
    chk(verdict_vld, 1'b1, "R2 hold valid");
    chk(verdict_accept, 1'b1, "R2 hold accept");

    // Hash sweeps: one-hot table and single cleared bit (R7, R8)
    for (int i = 0; i < 6; i++) begin
      for (int p = 0; p < 64; p++) begin
        logic [63:0] t;
        t = 64'h1 << p;
        {hash_hi, hash_lo} = t;
        run(mc_addr(i), 3'b001, (p >= 32) ? "R8 hi word" : "R7 lo word");
        t = ~t;
        {hash_hi, hash_lo} = t;
        run(mc_addr(i), 3'b001, "R8 cleared bit");
      end
    end

    // Gapped frames with junk on idle cycles (R10)
    hash_hi = 32'h0; hash_lo = 32'h0;
    for (int m = 0; m < 8; m++) begin
      {mode_prom, mode_mc_all, mode_mc_hash} = 3'(m);
      send(STA, 1'b1);
      chk(verdict_accept, ref_accept(STA, 3'(m), 32'h0, 32'h0), "R10 gap station");
      send(STA ^ 48'h0100, 1'b1);
      chk(verdict_accept, ref_accept(STA ^ 48'h0100, 3'(m), 32'h0, 32'h0),
          "R10 gap mismatch");
      send(mc_addr(7), 1'b1);
      chk(verdict_accept, ref_accept(mc_addr(7), 3'(m), 32'h0, 32'h0), "R10 gap mc");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule